// File: doc/BRIEF.md
# Programmable Down-Counter Mode Engine

This block is one timer channel. It holds a 16-bit count register, which software writes one byte at a time. It also holds a counting element that moves toward zero whenever the counter-clock enable pulses. A control-word strobe selects one of three behaviours. The first is an event counter that raises its output when terminal count is reached. The second is a one-shot fired by the gate input, which can be retriggered. The third is a periodic rate generator that drops its output for one counter clock in every period.

The whole channel runs in one system clock domain. The counter clock is modelled as the synchronous enable `cnt_en`. The gate input is sampled on each counter-clock pulse, and a trigger is the first pulse that finds gate high after it was sampled low. All outputs come straight from flops. These outputs are the output level, the null-count flag and the live counting-element value. Counting is binary only, and a loaded count of zero behaves as 65536.

A control word or count write in the same system cycle as an enable pulse takes precedence, and that enable pulse is dropped.

Top module: `tmr_channel`

## Requirements
- R1: After reset, `out_lvl` is 0, `null_cnt` is 0, `elem_val` is 0, and the channel is in terminal-count mode with low-byte-only writes.
- R2: A control word is accepted when `cw_bytes` is nonzero and `cw_mode` is 0, 1 or 2. Mode 0 is terminal count, 1 is one-shot and 2 is rate generator. Any other control word is ignored and leaves the outputs unchanged. An accepted control word sets `out_lvl` low for mode 0 and high for modes 1 and 2. The element does not count again until a complete count has been written.
- R3: The byte format is set by `cw_bytes`. With 1, a write sets the low byte and clears the high byte. With 2, a write sets the high byte and clears the low byte. With 3, the first write is the low byte and the second write is the high byte. A count of 0 loads as 0 and then decrements to 16'hFFFF.
- R4: In mode 0, a completed count write drives `out_lvl` low. The next enable pulse loads the count N without decrementing it. `out_lvl` rises on the (N+1)th pulse after the write and stays high until a new count or control word arrives.
- R5: In mode 0, gate low holds the element value and leaves `out_lvl` unchanged. A count written while gate is low still loads on the next pulse. `out_lvl` then rises N pulses after gate returns high.
- R6: In mode 0 with two-byte counts, the first byte drives `out_lvl` low in the next system cycle and halts counting. The second byte lets the new count load on the next pulse.
- R7: In mode 1, a trigger loads the count and drives `out_lvl` low on the same pulse. `out_lvl` returns high N pulses later. A further trigger restarts the pulse with the full count. A count written during a pulse does not change that pulse and is used from the next trigger onward.
- R8: In mode 2 with N of at least 2, the first pulse after the count write loads N with `out_lvl` high. `out_lvl` is low for exactly one pulse in every N, and the count reloads automatically.
- R9: In mode 2, gate low forces `out_lvl` high in the next system cycle and stops counting. A trigger reloads the count on that pulse.
- R10: In mode 2, a count written during a period does not change the remainder of that period. The new value is used at the next reload.
- R11: `null_cnt` is set by an accepted control word and by a completed count write. It is cleared only when the count register is transferred into the element.
- R12: `elem_val` changes only in cycles in which `cnt_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter-clock enable, one pulse per counter clock |
| gate | input | 1 | Gate level, synchronous to clk |
| cw_wr | input | 1 | Control-word strobe |
| cw_mode | input | 2 | Mode selection carried by the control word |
| cw_bytes | input | 2 | Byte-format selection carried by the control word |
| cnt_wr | input | 1 | Count byte write strobe |
| cnt_data | input | 8 | Count byte |
| out_lvl | output | 1 | Channel output level |
| null_cnt | output | 1 | High while a written count has not yet reached the element |
| elem_val | output | 16 | Live counting-element value |

## Verification
The properties assume that `gate` is already synchronous to `clk`. They also assume that a control-word strobe and a count write never arrive in the same cycle. The bench drives every strobe and every counter-clock pulse in separate system cycles, so no enable pulse is lost to a coinciding write. Rate-generator counts stay at 2 or above. Terminal-count and one-shot runs stay far below 65536 pulses, so a wrapped element never reaches terminal count a second time within a run.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MD_TERM    = 2'd0,
    MD_ONESHOT = 2'd1,
    MD_RATE    = 2'd2
  } tmr_mode_e;

  typedef enum logic [1:0] {
    BY_NONE = 2'd0,
    BY_LOW  = 2'd1,
    BY_HIGH = 2'd2,
    BY_PAIR = 2'd3
  } tmr_bytes_e;

endpackage

// File: rtl/tmr_ctl.sv
// Control word storage and count register byte assembly.
module tmr_ctl
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cw_wr,
  input  logic [1:0]        cw_mode,
  input  logic [1:0]        cw_bytes,
  input  logic              cnt_wr,
  input  logic [BYTE_W-1:0] cnt_data,
  output tmr_mode_e         mode,
  output logic              cw_evt,
  output logic              cr_done,
  output logic              first_byte,
  output logic [CNT_W-1:0]  cr
);

  tmr_bytes_e        bytes_q;
  logic              second_q;
  logic [BYTE_W-1:0] lo_hold_q;

  // Reserved encodings make the control word a no-op.
  assign cw_evt     = cw_wr && (cw_bytes != BY_NONE) && (cw_mode != 2'd3);
  assign cr_done    = !cw_evt && cnt_wr && ((bytes_q != BY_PAIR) || second_q);
  assign first_byte = !cw_evt && cnt_wr && (bytes_q == BY_PAIR) && !second_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= MD_TERM;
      bytes_q   <= BY_LOW;
      second_q  <= 1'b0;
      lo_hold_q <= '0;
      cr        <= '0;
    end else if (cw_evt) begin
      mode     <= tmr_mode_e'(cw_mode);
      bytes_q  <= tmr_bytes_e'(cw_bytes);
      second_q <= 1'b0;
    end else if (cnt_wr) begin
      case (bytes_q)
        BY_LOW:  cr <= {{BYTE_W{1'b0}}, cnt_data};
        BY_HIGH: cr <= {cnt_data, {BYTE_W{1'b0}}};
        BY_PAIR: begin
          if (!second_q) begin
            lo_hold_q <= cnt_data;
            second_q  <= 1'b1;
          end else begin
            cr       <= {cnt_data, lo_hold_q};
            second_q <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/tmr_trig.sv
// Gate sampler: a trigger is the first enable pulse seeing gate high after low.
module tmr_trig (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic gate,
  output logic trig
);

  logic gate_q;

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else if (tick) gate_q <= gate;
  end

  assign trig = tick && gate && !gate_q;

endmodule

// File: rtl/tmr_core.sv
// Counting element, output level and null-count tracking for the three modes.
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  tmr_mode_e        mode,
  input  logic             cw_evt,
  input  tmr_mode_e        cw_mode_new,
  input  logic             cr_done,
  input  logic             first_byte,
  input  logic             tick,
  input  logic             trig,
  input  logic             gate,
  input  logic [CNT_W-1:0] cr,
  output logic             out_lvl,
  output logic             null_cnt,
  output logic [CNT_W-1:0] elem
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic load_pend_q;
  logic cnt_ok_q;
  logic halt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      elem        <= '0;
      out_lvl     <= 1'b0;
      null_cnt    <= 1'b0;
      load_pend_q <= 1'b0;
      cnt_ok_q    <= 1'b0;
      halt_q      <= 1'b0;
    end else begin
      // Rate generator: gate low holds the output high regardless of the clock.
      if (mode == MD_RATE && !gate) out_lvl <= 1'b1;

      if (cw_evt) begin
        null_cnt    <= 1'b1;
        out_lvl     <= (cw_mode_new != MD_TERM);
        load_pend_q <= 1'b0;
        cnt_ok_q    <= 1'b0;
        halt_q      <= 1'b0;
      end else if (cr_done) begin
        null_cnt <= 1'b1;
        cnt_ok_q <= 1'b1;
        halt_q   <= 1'b0;
        case (mode)
          MD_TERM: begin
            load_pend_q <= 1'b1;
            out_lvl     <= 1'b0;
          end
          MD_RATE: if (!cnt_ok_q) load_pend_q <= 1'b1;
          default: ;
        endcase
      end else if (first_byte) begin
        if (mode == MD_TERM) begin
          halt_q  <= 1'b1;
          out_lvl <= 1'b0;
        end
      end else if (tick) begin
        case (mode)
          MD_TERM: begin
            if (load_pend_q) begin
              elem        <= cr;
              load_pend_q <= 1'b0;
              null_cnt    <= 1'b0;
            end else if (cnt_ok_q && gate && !halt_q) begin
              elem <= elem - ONE;
              if (elem == ONE) out_lvl <= 1'b1;
            end
          end
          MD_ONESHOT: begin
            if (trig && cnt_ok_q) begin
              elem     <= cr;
              out_lvl  <= 1'b0;
              null_cnt <= 1'b0;
            end else if (cnt_ok_q) begin
              elem <= elem - ONE;
              if (elem == ONE) out_lvl <= 1'b1;
            end
          end
          MD_RATE: begin
            if (load_pend_q || (trig && cnt_ok_q)) begin
              elem        <= cr;
              load_pend_q <= 1'b0;
              null_cnt    <= 1'b0;
              out_lvl     <= 1'b1;
            end else if (cnt_ok_q && gate) begin
              if (elem == TWO) begin
                elem    <= ONE;
                out_lvl <= 1'b0;
              end else if (elem == ONE) begin
                elem     <= cr;
                out_lvl  <= 1'b1;
                null_cnt <= 1'b0;
              end else begin
                elem <= elem - ONE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              gate,
  input  logic              cw_wr,
  input  logic [1:0]        cw_mode,
  input  logic [1:0]        cw_bytes,
  input  logic              cnt_wr,
  input  logic [BYTE_W-1:0] cnt_data,
  output logic              out_lvl,
  output logic              null_cnt,
  output logic [CNT_W-1:0]  elem_val
);

  tmr_mode_e        mode;
  logic             cw_evt;
  logic             cr_done;
  logic             first_byte;
  logic [CNT_W-1:0] cr;
  logic             trig;

  tmr_ctl #(.BYTE_W(BYTE_W)) ctl_i (
    .clk        (clk),
    .rst        (rst),
    .cw_wr      (cw_wr),
    .cw_mode    (cw_mode),
    .cw_bytes   (cw_bytes),
    .cnt_wr     (cnt_wr),
    .cnt_data   (cnt_data),
    .mode       (mode),
    .cw_evt     (cw_evt),
    .cr_done    (cr_done),
    .first_byte (first_byte),
    .cr         (cr)
  );

  tmr_trig trig_i (
    .clk  (clk),
    .rst  (rst),
    .tick (cnt_en),
    .gate (gate),
    .trig (trig)
  );

  tmr_core #(.CNT_W(CNT_W)) core_i (
    .clk         (clk),
    .rst         (rst),
    .mode        (mode),
    .cw_evt      (cw_evt),
    .cw_mode_new (tmr_mode_e'(cw_mode)),
    .cr_done     (cr_done),
    .first_byte  (first_byte),
    .tick        (cnt_en),
    .trig        (trig),
    .gate        (gate),
    .cr          (cr),
    .out_lvl     (out_lvl),
    .null_cnt    (null_cnt),
    .elem        (elem_val)
  );

endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              cnt_en,
  input logic              gate,
  input logic              cw_wr,
  input logic [1:0]        cw_mode,
  input logic [1:0]        cw_bytes,
  input logic              cnt_wr,
  input logic [BYTE_W-1:0] cnt_data,
  input logic              out_lvl,
  input logic              null_cnt,
  input logic [CNT_W-1:0]  elem_val
);

  logic [1:0] mode_sh;
  logic       cw_take;

  assign cw_take = cw_wr && (cw_bytes != 2'd0) && (cw_mode != 2'd3);

  // Mode as seen from the control-word port.
  always_ff @(posedge clk) begin
    if (rst) mode_sh <= 2'd0;
    else if (cw_take) mode_sh <= cw_mode;
  end

  assert_cw_sets_null_R11: assert property (@(posedge clk) disable iff (rst)
    cw_take |=> null_cnt);

  assert_null_holds_R11: assert property (@(posedge clk) disable iff (rst)
    (null_cnt && !cnt_en) |=> null_cnt);

  assert_value_on_tick_R12: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(elem_val));

  assert_term_out_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_sh == 2'd0 && out_lvl && !cw_wr && !cnt_wr) |=> out_lvl);

  assert_rate_gate_high_R9: assert property (@(posedge clk) disable iff (rst)
    (mode_sh == 2'd2 && !gate && !cw_wr) |=> out_lvl);

  assert_oneshot_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_sh == 2'd1 && !cnt_en && !cw_wr) |=> $stable(out_lvl));

endmodule

bind tmr_channel tmr_channel_chk #(.BYTE_W(BYTE_W)) chk_i (.*);

// File: tb/tmr_channel_tb_top.sv
`timescale 1ns/1ps
module tmr_channel_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_en = 1'b0;
  logic        gate = 1'b0;
  logic        cw_wr = 1'b0;
  logic [1:0]  cw_mode = 2'd0;
  logic [1:0]  cw_bytes = 2'd0;
  logic        cnt_wr = 1'b0;
  logic [7:0]  cnt_data = 8'd0;
  logic        out_lvl;
  logic        null_cnt;
  logic [15:0] elem_val;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmr_channel dut_i (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .gate(gate),
    .cw_wr(cw_wr), .cw_mode(cw_mode), .cw_bytes(cw_bytes),
    .cnt_wr(cnt_wr), .cnt_data(cnt_data),
    .out_lvl(out_lvl), .null_cnt(null_cnt), .elem_val(elem_val)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) cnt_en = 1'b1;
    @(negedge clk) cnt_en = 1'b0;
  endtask

  task automatic wr_cw(input logic [1:0] m, input logic [1:0] b);
    @(negedge clk) begin cw_wr = 1'b1; cw_mode = m; cw_bytes = b; end
    @(negedge clk) cw_wr = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk) begin cnt_wr = 1'b1; cnt_data = d; end
    @(negedge clk) cnt_wr = 1'b0;
  endtask

  task automatic run_until(input logic lvl, input int lim, output int n);
    n = 0;
    while (out_lvl !== lvl && n < lim) begin
      tick();
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int k;
    logic [15:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 out", 32'(out_lvl), 0);
    chk("R1 null", 32'(null_cnt), 0);
    chk("R1 elem", 32'(elem_val), 0);

    // R2 / R11: control word, no counting before a count
    wr_cw(2'd0, 2'd1);
    chk("R11 null after cw", 32'(null_cnt), 1);
    chk("R2 mode0 out low", 32'(out_lvl), 0);
    gate = 1'b1;
    repeat (3) tick();
    chk("R2 no count before write", 32'(elem_val), 0);
    wr_byte(8'd5);
    chk("R11 null after count", 32'(null_cnt), 1);
    tick();
    chk("R4 load no decrement", 32'(elem_val), 5);
    chk("R11 null cleared on load", 32'(null_cnt), 0);

    // R4 sweep of terminal count latency
    for (int n = 1; n <= 12; n++) begin
      wr_cw(2'd0, 2'd1);
      wr_byte(8'(n));
      run_until(1'b1, 40, k);
      chk($sformatf("R4 latency N=%0d", n), 32'(k), 32'(n + 1));
    end
    repeat (3) tick();
    chk("R4 out stays high", 32'(out_lvl), 1);

    // R2 ignored control words
    wr_cw(2'd1, 2'd0);
    chk("R2 ignored cw out", 32'(out_lvl), 1);
    chk("R2 ignored cw null", 32'(null_cnt), 0);
    wr_cw(2'd3, 2'd1);
    chk("R2 reserved mode out", 32'(out_lvl), 1);
    chk("R2 reserved mode null", 32'(null_cnt), 0);

    // R5 gate in mode 0
    wr_cw(2'd0, 2'd1);
    gate = 1'b0;
    wr_byte(8'd3);
    tick();
    chk("R5 loads with gate low", 32'(elem_val), 3);
    tick(); tick();
    chk("R5 gate low holds", 32'(elem_val), 3);
    chk("R5 out unchanged", 32'(out_lvl), 0);
    gate = 1'b1;
    run_until(1'b1, 20, k);
    chk("R5 rise after gate", 32'(k), 3);

    // R6 two-byte writes in mode 0
    wr_cw(2'd0, 2'd3);
    wr_byte(8'd2); wr_byte(8'd0);
    run_until(1'b1, 20, k);
    chk("R6 first run", 32'(k), 3);
    wr_byte(8'd4);
    chk("R6 first byte out low", 32'(out_lvl), 0);
    v = elem_val;
    tick(); tick();
    chk("R6 halted", 32'(elem_val), 32'(v));
    wr_byte(8'd0);
    chk("R11 null on second byte", 32'(null_cnt), 1);
    tick();
    chk("R6 second byte load", 32'(elem_val), 4);
    run_until(1'b1, 20, k);
    chk("R6 new count run", 32'(k), 4);

    // R3 byte formats and zero count
    wr_cw(2'd0, 2'd2);
    wr_byte(8'd1);
    tick();
    chk("R3 high byte only", 32'(elem_val), 32'h0100);
    wr_cw(2'd0, 2'd3);
    wr_byte(8'h34); wr_byte(8'h12);
    tick();
    chk("R3 byte pair", 32'(elem_val), 32'h1234);
    wr_cw(2'd0, 2'd1);
    wr_byte(8'd0);
    tick();
    chk("R3 zero load", 32'(elem_val), 0);
    tick();
    chk("R3 zero wraps", 32'(elem_val), 32'hFFFF);
    chk("R3 zero out low", 32'(out_lvl), 0);

    // R7 one-shot sweep
    wr_cw(2'd1, 2'd1);
    chk("R2 mode1 out high", 32'(out_lvl), 1);
    gate = 1'b0;
    wr_byte(8'd9);
    repeat (3) tick();
    chk("R7 no trigger no pulse", 32'(out_lvl), 1);
    for (int n = 1; n <= 8; n++) begin
      wr_byte(8'(n));
      gate = 1'b0;
      tick();
      gate = 1'b1;
      tick();
      chk($sformatf("R7 trigger out N=%0d", n), 32'(out_lvl), 0);
      chk($sformatf("R7 trigger load N=%0d", n), 32'(elem_val), 32'(n));
      run_until(1'b1, 20, k);
      chk($sformatf("R7 width N=%0d", n), 32'(k), 32'(n));
    end
    // retrigger
    wr_byte(8'd5);
    gate = 1'b0; tick(); gate = 1'b1; tick();
    tick(); tick();
    gate = 1'b0; tick(); gate = 1'b1; tick();
    chk("R7 retrigger reload", 32'(elem_val), 5);
    run_until(1'b1, 20, k);
    chk("R7 retrigger width", 32'(k), 5);
    // new count mid-pulse
    gate = 1'b0; tick(); gate = 1'b1; tick();
    wr_byte(8'd2);
    run_until(1'b1, 20, k);
    chk("R7 mid-pulse count ignored", 32'(k), 5);
    gate = 1'b0; tick(); gate = 1'b1; tick();
    chk("R7 new count next trigger", 32'(elem_val), 2);
    run_until(1'b1, 20, k);
    chk("R7 new width", 32'(k), 2);

    // R8 rate generator sweep
    for (int n = 2; n <= 9; n++) begin
      wr_cw(2'd2, 2'd1);
      chk($sformatf("R2 mode2 out high N=%0d", n), 32'(out_lvl), 1);
      gate = 1'b1;
      wr_byte(8'(n));
      tick();
      chk($sformatf("R8 load N=%0d", n), 32'(elem_val), 32'(n));
      run_until(1'b0, 40, k);
      chk($sformatf("R8 first low N=%0d", n), 32'(k), 32'(n - 1));
      tick();
      chk($sformatf("R8 one pulse low N=%0d", n), 32'(out_lvl), 1);
      chk($sformatf("R8 reload N=%0d", n), 32'(elem_val), 32'(n));
      run_until(1'b0, 40, k);
      chk($sformatf("R8 period N=%0d", n), 32'(k + 1), 32'(n));
    end

    // R9 gate control in mode 2
    wr_cw(2'd2, 2'd1);
    gate = 1'b1;
    wr_byte(8'd4);
    tick();
    run_until(1'b0, 20, k);
    gate = 1'b0;
    @(negedge clk);
    chk("R9 gate low forces high", 32'(out_lvl), 1);
    v = elem_val;
    repeat (3) tick();
    chk("R9 gate low stops", 32'(elem_val), 32'(v));
    repeat (5) @(negedge clk);
    chk("R12 idle cycles hold value", 32'(elem_val), 32'(v));
    gate = 1'b1;
    tick();
    chk("R9 trigger reload", 32'(elem_val), 4);
    chk("R9 out high on reload", 32'(out_lvl), 1);
    run_until(1'b0, 20, k);
    chk("R9 period after trigger", 32'(k), 3);

    // R10 new count mid-period
    tick();
    tick();
    wr_byte(8'd7);
    run_until(1'b0, 20, k);
    chk("R10 current period kept", 32'(k), 2);
    tick();
    chk("R10 next reload new count", 32'(elem_val), 7);
    run_until(1'b0, 20, k);
    chk("R10 new period", 32'(k + 1), 7);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule